// File: doc/BRIEF.md
# Four-Bank Interleaved Block Memory

This block models a main memory that refills a cache one block at a time. A block holds four 32-bit words. The words are spread across four banks so that consecutive word addresses fall in different banks. A requester presents a word address with a valid strobe. Only the block part of that address matters. The block spends one cycle latching the address. All four banks then run their access in parallel for a fixed latency. After that, the four words leave over a one-word-wide bus on consecutive cycles, with a valid strobe and a flag on the final word.

Because the bank accesses overlap, a block costs one long access plus one cycle per word. With the default latency of 15, the whole refill takes 20 cycles, where a single bank would need 65. The block serves one request at a time. A busy flag, and its inverse on the ready output, stop a second request from entering while a refill is in flight. Each bank's storage is a small synchronous-read array that is preloaded from a fixed formula, so every word can be predicted.

Top module: `ilv_block_mem`

## Requirements
- R1: After reset, busy, rd_valid and rd_last are 0 and req_ready is 1.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. busy is 1 from the cycle after acceptance through the 20th cycle after it, and 0 in the 21st.
- R3: Counting the cycle right after the accepting edge as cycle 1, cycle 1 is the address cycle and cycles 2 to 16 are the 15-cycle access. The first word is valid in cycle 17, so the block finishes at the end of cycle 20.
- R4: rd_valid is 1 in exactly four consecutive cycles (17 to 20) per request, with no gap between them.
- R5: Word i (i = 0..3) of a block comes from bank i and has word address 4*B + i, where B is req_addr[ADDR_W-1:2]. Words leave in the order bank 0, 1, 2, 3. A word with word address w holds {w[15:0], ~w[15:0]}.
- R6: rd_last is 1 only in the cycle that carries the fourth word (cycle 20).
- R7: A request raised while busy is 1 is refused. It changes neither the returned data nor the timing, and it does not start a refill once busy falls, as long as it is withdrawn before that.
- R8: req_addr[1:0] is ignored. Any word address inside a block returns the whole block, starting from bank 0.
- R9: rd_data is 0 in every cycle where rd_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Block read request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_addr | input | ADDR_W | Word address; the low two bits are ignored |
| busy | output | 1 | High while a refill is in flight |
| rd_valid | output | 1 | A data word is on rd_data |
| rd_data | output | 32 | Returned word |
| rd_last | output | 1 | Marks the fourth word of the block |

## Verification
Refills are requested at an aligned address, at an address whose low bits are 3 inside the same block, and at the highest block of the address space. Together these show whether bank selection uses only the block bits, whether the word order always starts at bank 0, and whether the top address wraps correctly. A refill with a conflicting request held high during the access window shows whether requests made while busy are really refused. Every cycle from acceptance to one cycle past completion is checked, so a latency that is one cycle short or long shows up as a fault in busy, rd_valid or rd_last.

// File: rtl/ilv_mem_pkg.sv
package ilv_mem_pkg;
  localparam int WORD_W = 32;
  localparam int BANKS  = 4;
  localparam int SEL_W  = $clog2(BANKS);

  function automatic logic [WORD_W-1:0] fill_word(input int unsigned w);
    logic [31:0] wv;
    wv = w;
    return {wv[15:0], ~wv[15:0]};
  endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
  import ilv_mem_pkg::*;
#(
  parameter int BANK_ID = 0,
  parameter int DEPTH_AW = 6
) (
  input  logic                clk,
  input  logic                rd_en,
  input  logic [DEPTH_AW-1:0] rd_addr,
  output logic [WORD_W-1:0]   rd_q
);
  localparam int DEPTH = 1 << DEPTH_AW;

  logic [WORD_W-1:0] mem [DEPTH];

  // Preload: row i of bank k holds word address i*BANKS + k
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = fill_word(i * BANKS + BANK_ID);
    end
  end

  // Synchronous read, no reset on the data path (RAM friendly)
  always_ff @(posedge clk) begin
    if (rd_en) rd_q <= mem[rd_addr];
  end
endmodule

// File: rtl/ilv_phase_seq.sv
module ilv_phase_seq
  import ilv_mem_pkg::*;
#(
  parameter int ACCESS_LAT = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             busy,
  output logic             bank_rd,
  output logic             xfer,
  output logic [SEL_W-1:0] xfer_idx,
  output logic             xfer_last
);
  localparam int TOTAL_I = 1 + ACCESS_LAT + BANKS;
  localparam int PH_W    = $clog2(TOTAL_I + 1);
  localparam logic [PH_W-1:0] DATA_START = PH_W'(1 + ACCESS_LAT);
  localparam logic [PH_W-1:0] RD_PHASE   = PH_W'(ACCESS_LAT);
  localparam logic [PH_W-1:0] TOTAL      = PH_W'(TOTAL_I);
  localparam logic [PH_W-1:0] LAST_OUT   = PH_W'(TOTAL_I - 1);

  // ph = number of the current cycle since acceptance, 0 when idle
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] off;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (ph == '0) begin
      if (start) ph <= PH_W'(1);
    end else if (ph == TOTAL) begin
      ph <= '0;
    end else begin
      ph <= ph + PH_W'(1);
    end
  end

  always_comb begin
    busy      = (ph != '0);
    bank_rd   = (ph == RD_PHASE);
    xfer      = (ph >= DATA_START) && (ph < TOTAL);
    off       = ph - DATA_START;
    xfer_idx  = off[SEL_W-1:0];
    xfer_last = (ph == LAST_OUT);
  end

  p_phase_range_r3: assert property (@(posedge clk) disable iff (rst)
    ph <= TOTAL);
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ph != '0 && ph != TOTAL) |=> (ph == $past(ph) + PH_W'(1)));
  p_phase_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (ph == TOTAL) |=> (ph == '0));
endmodule

// File: rtl/ilv_block_mem.sv
module ilv_block_mem
  import ilv_mem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int ACCESS_LAT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              busy,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_last
);
  localparam int BLK_AW = ADDR_W - SEL_W;

  logic              start;
  logic              bank_rd;
  logic              xfer;
  logic [SEL_W-1:0]  xfer_idx;
  logic              xfer_last;
  logic [BLK_AW-1:0] blk_q;
  logic [WORD_W-1:0] bank_q [BANKS];

  assign req_ready = ~busy;
  assign start     = req_valid & req_ready;

  ilv_phase_seq #(.ACCESS_LAT(ACCESS_LAT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .bank_rd   (bank_rd),
    .xfer      (xfer),
    .xfer_idx  (xfer_idx),
    .xfer_last (xfer_last)
  );

  // Block address latched once; the word offset bits are dropped
  always_ff @(posedge clk) begin
    if (rst) blk_q <= '0;
    else if (start) blk_q <= req_addr[ADDR_W-1:SEL_W];
  end

  for (genvar k = 0; k < BANKS; k++) begin : g_bank
    ilv_bank #(.BANK_ID(k), .DEPTH_AW(BLK_AW)) u_bank (
      .clk     (clk),
      .rd_en   (bank_rd),
      .rd_addr (blk_q),
      .rd_q    (bank_q[k])
    );
  end

  // Registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= xfer;
      rd_last  <= xfer_last;
      rd_data  <= xfer ? bank_q[xfer_idx] : '0;
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);
  p_valid_inside_busy_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);
  p_valid_ends_on_last_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_valid) |-> $past(rd_last));
  p_last_with_valid_r6: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);
  p_block_held_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(blk_q));
  p_idle_data_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));
endmodule

// File: tb/tb_ilv_block_mem.sv
module tb_ilv_block_mem;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_addr = '0;
  logic        req_ready;
  logic        busy;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_last;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ilv_block_mem #(.ADDR_W(8), .ACCESS_LAT(15)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] word_of(input logic [7:0] w);
    logic [15:0] w16;
    w16 = {8'h00, w};
    return {w16, ~w16};
  endfunction

  // One refill; optionally hold a conflicting request during cycles 3..12
  task automatic run_block(input logic [7:0] a, input bit poke, input string tag);
    logic [7:0] w;
    @(negedge clk);
    chk({tag, " R2 ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(posedge clk);
    for (int n = 1; n <= 21; n++) begin
      @(negedge clk);
      if (n == 1) req_valid = 1'b0;
      chk({tag, " R2 busy"}, 32'(busy), 32'(n <= 20));
      chk({tag, " R7 ready"}, 32'(req_ready), 32'(n > 20));
      chk({tag, " R3 R4 valid"}, 32'(rd_valid), 32'(n >= 17 && n <= 20));
      chk({tag, " R6 last"}, 32'(rd_last), 32'(n == 20));
      if (n >= 17 && n <= 20) begin
        w = {a[7:2], 2'(n - 17)};
        chk({tag, " R5 R8 data"}, rd_data, word_of(w));
      end else begin
        chk({tag, " R9 idle data"}, rd_data, 32'd0);
      end
      if (poke && n == 3) begin
        req_valid = 1'b1;
        req_addr  = ~a;
      end
      if (poke && n == 12) req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 busy", 32'(busy), 32'd0);
    chk("R1 valid", 32'(rd_valid), 32'd0);
    chk("R1 last", 32'(rd_last), 32'd0);
    chk("R1 ready", 32'(req_ready), 32'd1);
    run_block(8'h14, 1'b0, "aligned");
    run_block(8'h17, 1'b0, "offset3");
    run_block(8'hFD, 1'b0, "topblock");
    run_block(8'h20, 1'b1, "busyreq");
    @(negedge clk);
    chk("R7 no late start", 32'(busy), 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule